// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block produces the strobes and port values an 8-bit controller needs to reach external program and data memory over a multiplexed bus. The controller runs a machine cycle of twelve oscillator clocks split into two six-clock halves. Each half carries one address latch pulse followed by one program-store read strobe. The low address byte and the data share one 8-bit port, and the high address byte goes out on a second port.

The core tells the block whether code is fetched externally and supplies the fetch address. It asks for a data transfer (read or write, with a 16-bit or an 8-bit address) while the block flags the last clock of a machine cycle. The whole of the next machine cycle then becomes a data cycle. In it, the second latch pulse and both program-store strobes are dropped, and a six-clock read or write strobe is issued. A software bit can park the latch output when code runs internally. That bit is overridden during data transfers, table reads from code space, external execution, idle and power-down. Idle and power-down force fixed pin levels and restart the machine cycle from its first clock when they end.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is held, rd_n and wr_n are 1, rdata_valid and mc_last are 0, p0_oe is 0, and ale is 1, because the cycle sits at phase 0.
- R2: Outside data cycles, with the latch not parked, ale is 1 in phases 0, 1, 6 and 7 of each 12-clock machine cycle and 0 in all other phases. Phases count from 0 at the first clock after reset.
- R3: With fetch_ext=1 and no data cycle, psen_n is 0 in phases 3-5 and 9-11 and 1 elsewhere. With fetch_ext=0, psen_n stays 1.
- R4: If acc_req is 1 on the clock edge that ends a phase where mc_last=1, the next machine cycle is a data cycle. In a data cycle, ale pulses only in phases 0 and 1, and psen_n stays 1 for all 12 phases.
- R5: In a read data cycle, rd_n is 0 in phases 5 through 10, which is 3 clocks after ale falls, for 6 clocks. p0_in is captured at the edge that ends phase 10. rdata shows the captured value, and rdata_valid is 1 during phase 11 only.
- R6: In a write data cycle, wr_n is 0 in phases 5 through 10, and p0_out carries acc_wdata with p0_oe=1 from phase 4 to phase 10. rd_n and wr_n are never 0 together.
- R7: p0_oe=1 and p0_out shows the low address byte in phases 0-2 of a data cycle, and in phases 0-2 and 6-8 of an external fetch cycle (code_addr[7:0]). In every other phase where no write data is due, p0_oe=0.
- R8: p2_out shows acc_addr[15:8] during a data cycle with acc_wide=1, and p2_latch during a data cycle with acc_wide=0. Outside data cycles it shows code_addr[15:8] when fetch_ext=1, and p2_latch otherwise.
- R9: With ale_off=1, fetch_ext=0, movc_active=0 and no data cycle, ale is held at 1 and does not pulse. Any one of fetch_ext, movc_active or a data cycle restores the normal pulses.
- R10: With idle_mode=1 and pdown_mode=0, ale=1, psen_n=1, rd_n=wr_n=1 and p0_oe=0. p2_out is code_addr[15:8] if fetch_ext=1, and p2_latch otherwise.
- R11: With pdown_mode=1, ale=0, psen_n=0, rd_n=wr_n=1, p0_oe=0 and p2_out=p2_latch. Power-down takes priority over idle.
- R12: While idle_mode or pdown_mode is 1, the phase is held at 0 and any pending data cycle is dropped. mc_last is 1 only in phase 11, which is 11 clocks after a mode ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_ext | input | 1 | Code is fetched from external memory |
| code_addr | input | 16 | Current fetch address |
| movc_active | input | 1 | A table read from code space is running |
| ale_off | input | 1 | Software latch-park bit |
| idle_mode | input | 1 | Idle mode flag |
| pdown_mode | input | 1 | Power-down mode flag |
| acc_req | input | 1 | Data transfer request, sampled while mc_last=1 |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 16-bit address, 0 = 8-bit address |
| acc_addr | input | 16 | Data address |
| acc_wdata | input | 8 | Write data |
| p2_latch | input | 8 | Upper port register contents |
| p0_in | input | 8 | Value read from the multiplexed port |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| p0_out | output | 8 | Multiplexed address/data port value |
| p0_oe | output | 1 | Multiplexed port drive enable |
| p2_out | output | 8 | Upper port value |
| rdata | output | 8 | Captured read data |
| rdata_valid | output | 1 | rdata updated in this clock |
| mc_last | output | 1 | Last phase of the machine cycle |

## Verification
The pin outputs are decoded from the registered phase, so each one is due in the same clock as the phase it belongs to. Mode flags and the fetch address act within that clock. A request takes effect one edge after mc_last, and read data appears one edge after phase 10. The bench keeps its own phase and data-cycle record, advanced at every rising edge from the inputs present at that edge. It changes inputs a quarter period after the edge and compares every output a little later, so each expected value is computed for exactly the clock in which it is due.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int unsigned MC_LEN = 12;
  localparam int unsigned PH_W   = $clog2(MC_LEN);
  typedef logic [PH_W-1:0] phase_t;

  localparam phase_t PH_LAST  = phase_t'(MC_LEN - 1);
  localparam phase_t PH_HALF  = phase_t'(MC_LEN / 2);
  localparam phase_t ALE_LAST = phase_t'(1);   // last latch phase within a half
  localparam phase_t ADR_LAST = phase_t'(2);   // last address-drive phase within a half
  localparam phase_t PSN_BEG  = phase_t'(3);   // first program-store phase within a half
  localparam phase_t WD_BEG   = phase_t'(4);   // write data drive start
  localparam phase_t XF_BEG   = phase_t'(5);   // read/write strobe start
  localparam phase_t XF_END   = phase_t'(10);  // read/write strobe end, read capture
endpackage

// File: rtl/xbus_phase_gen.sv
module xbus_phase_gen
  import xbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hold,
  output phase_t phase,
  output logic   last
);
  phase_t phase_q, phase_d;
  logic   adv;

  assign adv = 1'b1;

  always_comb begin
    if (hold)                 phase_d = '0;
    else if (phase_q == PH_LAST) phase_d = '0;
    else                      phase_d = phase_q + phase_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   phase_q <= '0;
    else if (adv) phase_q <= phase_d;
  end

  assign phase = phase_q;
  assign last  = (phase_q == PH_LAST) && !hold;
endmodule

// File: rtl/xbus_xfer_ctl.sv
module xbus_xfer_ctl
  import xbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              last,
  input  phase_t            phase,
  input  logic              req,
  input  logic              req_wr,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] bus_in,
  output logic              dc,
  output logic              dc_wr,
  output logic              dc_wide,
  output logic [ADDR_W-1:0] dc_addr,
  output logic [DATA_W-1:0] dc_wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic              dc_q, dc_d, wr_q, wide_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rv_q, rv_d, take, cap;

  assign take = last && req && !hold;
  assign cap  = dc_q && !wr_q && (phase == XF_END);

  always_comb begin
    dc_d = dc_q;
    if (hold)      dc_d = 1'b0;
    else if (last) dc_d = req;
    rv_d = cap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dc_q <= 1'b0;
      rv_q <= 1'b0;
    end else begin
      dc_q <= dc_d;
      rv_q <= rv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      wr_q    <= req_wr;
      wide_q  <= req_wide;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdata_q <= '0;
    else if (cap) rdata_q <= bus_in;
  end

  assign dc       = dc_q;
  assign dc_wr    = wr_q;
  assign dc_wide  = wide_q;
  assign dc_addr  = addr_q;
  assign dc_wdata = wdata_q;
  assign rdata    = rdata_q;
  assign rvalid   = rv_q;
endmodule

// File: rtl/xbus_pin_dec.sv
module xbus_pin_dec
  import xbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  phase_t            phase,
  input  logic              idle,
  input  logic              pdown,
  input  logic              fetch_ext,
  input  logic              movc,
  input  logic              ale_off,
  input  logic [ADDR_W-1:0] code_addr,
  input  logic [HI_W-1:0]   p2_latch,
  input  logic              dc,
  input  logic              dc_wr,
  input  logic              dc_wide,
  input  logic [ADDR_W-1:0] dc_addr,
  input  logic [DATA_W-1:0] dc_wdata,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] p0_out,
  output logic              p0_oe,
  output logic [HI_W-1:0]   p2_out
);
  phase_t sub;
  logic   upper, parked, in_xfer, lat_pulse;

  always_comb begin
    upper     = (phase >= PH_HALF);
    sub       = upper ? (phase - PH_HALF) : phase;
    in_xfer   = dc && (phase >= XF_BEG) && (phase <= XF_END);
    lat_pulse = (sub <= ALE_LAST) && !(dc && upper);
    parked    = ale_off && !fetch_ext && !dc && !movc;

    ale    = 1'b0;
    psen_n = 1'b1;
    rd_n   = 1'b1;
    wr_n   = 1'b1;
    p0_oe  = 1'b0;
    p0_out = '0;
    p2_out = p2_latch;

    if (pdown) begin
      psen_n = 1'b0;
    end else if (idle) begin
      ale = 1'b1;
      if (fetch_ext) p2_out = code_addr[ADDR_W-1:DATA_W];
    end else begin
      ale    = parked ? 1'b1 : lat_pulse;
      psen_n = !(fetch_ext && !dc && (sub >= PSN_BEG));
      rd_n   = !(in_xfer && !dc_wr);
      wr_n   = !(in_xfer && dc_wr);
      if (dc) begin
        if (phase <= ADR_LAST) begin
          p0_oe  = 1'b1;
          p0_out = dc_addr[DATA_W-1:0];
        end else if (dc_wr && (phase >= WD_BEG) && (phase <= XF_END)) begin
          p0_oe  = 1'b1;
          p0_out = dc_wdata;
        end
        if (dc_wide) p2_out = dc_addr[ADDR_W-1:DATA_W];
      end else if (fetch_ext) begin
        if (sub <= ADR_LAST) begin
          p0_oe  = 1'b1;
          p0_out = code_addr[DATA_W-1:0];
        end
        p2_out = code_addr[ADDR_W-1:DATA_W];
      end
    end
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_ext,
  input  logic [ADDR_W-1:0] code_addr,
  input  logic              movc_active,
  input  logic              ale_off,
  input  logic              idle_mode,
  input  logic              pdown_mode,
  input  logic              acc_req,
  input  logic              acc_write,
  input  logic              acc_wide,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [HI_W-1:0]   p2_latch,
  input  logic [DATA_W-1:0] p0_in,
  output logic              ale,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] p0_out,
  output logic              p0_oe,
  output logic [HI_W-1:0]   p2_out,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_valid,
  output logic              mc_last
);
  phase_t            phase;
  logic              hold, last, dc, dc_wr, dc_wide;
  logic [ADDR_W-1:0] dc_addr;
  logic [DATA_W-1:0] dc_wdata;

  assign hold = idle_mode || pdown_mode;

  xbus_phase_gen u_phase (
    .clk(clk), .rst_n(rst_n), .hold(hold), .phase(phase), .last(last)
  );

  xbus_xfer_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .hold(hold), .last(last), .phase(phase),
    .req(acc_req), .req_wr(acc_write), .req_wide(acc_wide),
    .req_addr(acc_addr), .req_wdata(acc_wdata), .bus_in(p0_in),
    .dc(dc), .dc_wr(dc_wr), .dc_wide(dc_wide), .dc_addr(dc_addr),
    .dc_wdata(dc_wdata), .rdata(rdata), .rvalid(rdata_valid)
  );

  xbus_pin_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .phase(phase), .idle(idle_mode), .pdown(pdown_mode),
    .fetch_ext(fetch_ext), .movc(movc_active), .ale_off(ale_off),
    .code_addr(code_addr), .p2_latch(p2_latch), .dc(dc), .dc_wr(dc_wr),
    .dc_wide(dc_wide), .dc_addr(dc_addr), .dc_wdata(dc_wdata),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .p0_out(p0_out), .p0_oe(p0_oe), .p2_out(p2_out)
  );

  assign mc_last = last;
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              idle_mode,
  input logic              pdown_mode,
  input logic              ale,
  input logic              psen_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [DATA_W-1:0] p0_out,
  input logic              p0_oe,
  input logic              rdata_valid,
  input logic              mc_last
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R6
  AST_NO_PSEN_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> psen_n); // R4
  AST_RVALID_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> $past(!rd_n)); // R5
  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> (p0_oe && $stable(p0_out))); // R6
  AST_PDOWN_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    pdown_mode |-> (!ale && !psen_n && !p0_oe && rd_n && wr_n)); // R11
  AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_mode && !pdown_mode) |-> (ale && psen_n && !p0_oe)); // R10
  AST_MC_LAST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mc_last |=> !mc_last); // R12
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle_mode(idle_mode), .pdown_mode(pdown_mode),
  .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .p0_out(p0_out),
  .p0_oe(p0_oe), .rdata_valid(rdata_valid), .mc_last(mc_last)
);

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_ext, movc_active, ale_off, idle_mode, pdown_mode;
  logic [15:0] code_addr, acc_addr;
  logic        acc_req, acc_write, acc_wide;
  logic [7:0]  acc_wdata, p2_latch, p0_in;
  logic        ale, psen_n, rd_n, wr_n, p0_oe, rdata_valid, mc_last;
  logic [7:0]  p0_out, p2_out, rdata;

  int checks = 0;
  int fails  = 0;

  // bench model state
  int          m_ph;
  bit          m_dc, m_wr, m_wide, m_rv;
  logic [15:0] m_addr;
  logic [7:0]  m_wdata, m_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_ext(fetch_ext), .code_addr(code_addr),
    .movc_active(movc_active), .ale_off(ale_off), .idle_mode(idle_mode),
    .pdown_mode(pdown_mode), .acc_req(acc_req), .acc_write(acc_write),
    .acc_wide(acc_wide), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .p2_latch(p2_latch), .p0_in(p0_in), .ale(ale), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n), .p0_out(p0_out), .p0_oe(p0_oe),
    .p2_out(p2_out), .rdata(rdata), .rdata_valid(rdata_valid), .mc_last(mc_last)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s phase=%0d actual=%h expected=%h", req, what, m_ph, act, exp);
    end
  endtask

  function automatic bit exp_ale();
    int s = m_ph % 6;
    if (pdown_mode) return 1'b0;
    if (idle_mode)  return 1'b1;
    if (ale_off && !fetch_ext && !m_dc && !movc_active) return 1'b1;
    return (s < 2) && !(m_dc && m_ph >= 6);
  endfunction

  function automatic logic [7:0] exp_p2();
    if (pdown_mode) return p2_latch;
    if (idle_mode)  return fetch_ext ? code_addr[15:8] : p2_latch;
    if (m_dc)       return m_wide ? m_addr[15:8] : p2_latch;
    return fetch_ext ? code_addr[15:8] : p2_latch;
  endfunction

  task automatic check_all();
    int s = m_ph % 6;
    bit e_psen, e_rd, e_wr, e_oe;
    logic [7:0] e_p0;
    string tag;
    e_psen = 1'b1; e_rd = 1'b1; e_wr = 1'b1; e_oe = 1'b0; e_p0 = 8'h00;
    if (pdown_mode) e_psen = 1'b0;
    else if (!idle_mode) begin
      e_psen = !(fetch_ext && !m_dc && s >= 3);
      e_rd   = !(m_dc && !m_wr && m_ph >= 5 && m_ph <= 10);
      e_wr   = !(m_dc &&  m_wr && m_ph >= 5 && m_ph <= 10);
      if (m_dc) begin
        if (m_ph <= 2) begin e_oe = 1'b1; e_p0 = m_addr[7:0]; end
        else if (m_wr && m_ph >= 4 && m_ph <= 10) begin e_oe = 1'b1; e_p0 = m_wdata; end
      end else if (fetch_ext && s <= 2) begin
        e_oe = 1'b1; e_p0 = code_addr[7:0];
      end
    end
    if (pdown_mode) tag = "R11";
    else if (idle_mode) tag = "R10";
    else if (ale_off && !fetch_ext && !m_dc && !movc_active) tag = "R9";
    else if (m_dc) tag = "R4";
    else tag = "R2";
    chk(tag, "ale", 16'(ale), 16'(exp_ale()));
    chk(pdown_mode ? "R11" : idle_mode ? "R10" : m_dc ? "R4" : "R3", "psen_n", 16'(psen_n), 16'(e_psen));
    chk("R5", "rd_n", 16'(rd_n), 16'(e_rd));
    chk("R6", "wr_n", 16'(wr_n), 16'(e_wr));
    chk("R7", "p0_oe", 16'(p0_oe), 16'(e_oe));
    if (e_oe) chk((m_dc && m_ph > 2) ? "R6" : "R7", "p0_out", 16'(p0_out), 16'(e_p0));
    chk("R8", "p2_out", 16'(p2_out), 16'(exp_p2()));
    chk("R5", "rdata_valid", 16'(rdata_valid), 16'(m_rv));
    if (m_rv) chk("R5", "rdata", 16'(rdata), 16'(m_rdata));
    chk("R12", "mc_last", 16'(mc_last), 16'(m_ph == 11 && !idle_mode && !pdown_mode));
  endtask

  // advance model at a rising edge using inputs present at that edge
  task automatic model_step();
    bit cap = m_dc && !m_wr && m_ph == 10;
    if (cap) m_rdata = p0_in;
    if (idle_mode || pdown_mode) begin
      m_dc = 1'b0; m_ph = 0;
    end else begin
      if (m_ph == 11) begin
        m_dc = acc_req;
        if (acc_req) begin
          m_wr = acc_write; m_wide = acc_wide; m_addr = acc_addr; m_wdata = acc_wdata;
        end
        m_ph = 0;
      end else m_ph = m_ph + 1;
    end
    m_rv = cap;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    int k = 0;
    int mode_cnt = 0;
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0;
    fetch_ext = 0; movc_active = 0; ale_off = 0; idle_mode = 0; pdown_mode = 0;
    code_addr = 16'h0000; acc_addr = 16'h0000; acc_req = 0; acc_write = 0; acc_wide = 0;
    acc_wdata = 8'h00; p2_latch = 8'h5A; p0_in = 8'h00;
    m_ph = 0; m_dc = 0; m_wr = 0; m_wide = 0; m_rv = 0; m_addr = '0; m_wdata = '0; m_rdata = '0;
    #(CLK_PERIOD * 3 + 2);
    // R1 reset state
    chk("R1", "rd_n", 16'(rd_n), 16'd1);
    chk("R1", "wr_n", 16'(wr_n), 16'd1);
    chk("R1", "rdata_valid", 16'(rdata_valid), 16'd0);
    chk("R1", "mc_last", 16'(mc_last), 16'd0);
    chk("R1", "p0_oe", 16'(p0_oe), 16'd0);
    chk("R1", "ale", 16'(ale), 16'd1);
    @(negedge clk) rst_n = 1'b1;
    check_all();
    while (k < 320) begin
      @(posedge clk);
      model_step();
      #(CLK_PERIOD/4);
      p0_in = 8'($urandom);
      acc_req = 1'b0;
      if (m_ph == 0) begin
        if (mode_cnt > 0) begin
          mode_cnt--;
          if (mode_cnt == 0) begin idle_mode = 0; pdown_mode = 0; end
        end else begin
          code_addr = 16'($urandom);
          p2_latch  = 8'($urandom);
          case (k)
            0: begin fetch_ext = 0; ale_off = 0; movc_active = 0; end  // R2 directed
            1: begin fetch_ext = 1; end                                 // R3 directed
            2: begin fetch_ext = 1; end                                 // R5 wide read cycle
            3: begin fetch_ext = 0; end                                 // R6 narrow write cycle
            4: begin ale_off = 1; fetch_ext = 0; movc_active = 0; end   // R9 parked
            5: begin movc_active = 1; end                               // R9 override
            6: begin fetch_ext = 1; ale_off = 0; movc_active = 0;
                     idle_mode = 1; mode_cnt = 5; end                   // R10 directed
            7: begin pdown_mode = 1; mode_cnt = 5; end                  // R11 directed
            default: begin
              int r = int'($urandom % 16);
              fetch_ext   = ($urandom % 3) != 0;
              ale_off     = ($urandom % 3) == 0;
              movc_active = ($urandom % 4) == 0;
              if (r == 0) begin idle_mode = 1; mode_cnt = 2 + int'($urandom % 6); end
              else if (r == 1) begin pdown_mode = 1; mode_cnt = 2 + int'($urandom % 6); end
              else if (r == 2) begin idle_mode = 1; pdown_mode = 1; mode_cnt = 3; end
            end
          endcase
          k++;
        end
      end
      if (m_ph == 6) code_addr = 16'($urandom);
      if (m_ph == 11) begin
        acc_addr  = 16'($urandom);
        acc_wdata = 8'($urandom);
        if (k == 2)      begin acc_req = 1; acc_write = 0; acc_wide = 1; end
        else if (k == 3) begin acc_req = 1; acc_write = 1; acc_wide = 0; end
        else if (k >= 8) begin
          acc_req   = ($urandom % 3) == 0;
          acc_write = $urandom % 2;
          acc_wide  = $urandom % 2;
        end
      end
      #1;
      check_all();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule